// File: doc/BRIEF.md
# Instruction Control Decoder for a Single-Cycle Core

This block turns the operation field and the function field of an instruction into the full set of steering and enable signals that a single-cycle datapath needs in the same cycle. It covers register-to-register add, subtract, AND and OR, word load, word store and branch-if-equal. It is purely combinational: every output is a function of the two 6-bit fields of the current instruction and of nothing else.

Decoding happens at two levels. A primary decoder looks only at the operation field. It produces the datapath steering and enable bits and a 2-bit operation class. A second decoder turns that class into a 4-bit ALU function code. For the register-to-register class it consults the function field. For the memory class it forces add, and for the branch class it forces subtract. Any operation or function code outside the supported set yields an output that writes nothing, touches no memory and takes no branch.

Top module: `ctl_decode_top`

## Requirements
- R1: Operation 0x00 with a supported function code drives wr_sel_rd=1, opb_sel_imm=0, wb_sel_mem=0, rf_we=1, dmem_re=0, dmem_we=0, br_eq=0 and op_class=2'b10.
- R2: Operation 0x23 (word load) drives wr_sel_rd=0, opb_sel_imm=1, wb_sel_mem=1, rf_we=1, dmem_re=1, dmem_we=0, br_eq=0 and op_class=2'b00.
- R3: Operation 0x2B (word store) drives opb_sel_imm=1, rf_we=0, dmem_re=0, dmem_we=1, br_eq=0 and op_class=2'b00.
- R4: Operation 0x04 (branch-if-equal) drives opb_sel_imm=0, rf_we=0, dmem_re=0, dmem_we=0, br_eq=1 and op_class=2'b01.
- R5: Under op_class 2'b00 the ALU function is 4'b0010 (add), and under op_class 2'b01 it is 4'b0110 (subtract), whatever the function field holds.
- R6: Under op_class 2'b10 the function field selects the ALU function: 0x20 gives 4'b0010, 0x22 gives 4'b0110, 0x24 gives 4'b0000 and 0x25 gives 4'b0001.
- R7: Any operation code other than 0x00, 0x23, 0x2B and 0x04 drives rf_we, dmem_re, dmem_we and br_eq to 0 and op_class to 2'b11.
- R8: Operation 0x00 with a function code other than 0x20, 0x22, 0x24 and 0x25 drives rf_we, dmem_re, dmem_we and br_eq to 0.
- R9: dmem_re and dmem_we are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Operation field of the current instruction |
| funct | input | 6 | Function field of the current instruction |
| wr_sel_rd | output | 1 | 1: destination register comes from the rd field; 0: from the rt field |
| opb_sel_imm | output | 1 | 1: second ALU operand is the extended immediate; 0: second register |
| wb_sel_mem | output | 1 | 1: write-back data comes from data memory; 0: from the ALU |
| rf_we | output | 1 | Register file write enable |
| dmem_re | output | 1 | Data memory read enable |
| dmem_we | output | 1 | Data memory write enable |
| br_eq | output | 1 | Instruction is a branch-if-equal |
| op_class | output | 2 | Operation class passed between the two decoder levels |
| alu_fn | output | 4 | ALU function code |

## Verification
The bench drives memory and branch instructions with function fields that would decode to a different operation in register-to-register form. A decoder that let the function field leak through would then produce AND or OR where add or subtract is required. It also sweeps all 64 operation codes. An overlooked code would leave a write or memory enable set, and a loose comparison would make both memory enables rise together. Unsupported function codes under the register-to-register operation are driven as well, including 0x00. A decoder that gated only on the operation code would still write the register file for these.

// File: rtl/ctl_pkg.sv
// Shared encodings for the instruction control decoder.
// Assumes 6-bit operation and function fields and a 4-bit ALU function code.
package ctl_pkg;
    localparam int OPC_W = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 4;
    localparam int CLS_W = 2;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;

    typedef enum logic [CLS_W-1:0] {
        CLS_MEM  = 2'b00,
        CLS_BR   = 2'b01,
        CLS_REG  = 2'b10,
        CLS_NONE = 2'b11
    } op_class_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110
    } alu_fn_e;

    typedef struct packed {
        logic      wr_sel_rd;
        logic      opb_sel_imm;
        logic      wb_sel_mem;
        logic      rf_we;
        logic      dmem_re;
        logic      dmem_we;
        logic      br_eq;
        op_class_e cls;
    } main_ctl_t;
endpackage

// File: rtl/ctl_main_dec.sv
// Primary decoder: maps the operation field to datapath steering, enables and
// an operation class. Assumes nothing beyond the operation field; unknown
// codes produce an all-disabled bundle with the reserved class.
module ctl_main_dec
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output main_ctl_t        ctl
);
    // Decode the operation field into the control bundle.
    always_comb begin
        ctl = '{wr_sel_rd: 1'b0, opb_sel_imm: 1'b0, wb_sel_mem: 1'b0,
                rf_we: 1'b0, dmem_re: 1'b0, dmem_we: 1'b0, br_eq: 1'b0,
                cls: CLS_NONE};
        case (opcode)
            OPC_REG: begin
                ctl.wr_sel_rd = 1'b1;
                ctl.rf_we     = 1'b1;
                ctl.cls       = CLS_REG;
            end
            OPC_LOAD: begin
                ctl.opb_sel_imm = 1'b1;
                ctl.wb_sel_mem  = 1'b1;
                ctl.rf_we       = 1'b1;
                ctl.dmem_re     = 1'b1;
                ctl.cls         = CLS_MEM;
            end
            OPC_STORE: begin
                ctl.opb_sel_imm = 1'b1;
                ctl.dmem_we     = 1'b1;
                ctl.cls         = CLS_MEM;
            end
            OPC_BEQ: begin
                ctl.br_eq = 1'b1;
                ctl.cls   = CLS_BR;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ctl_alu_dec.sv
// Second-level decoder: turns the operation class and the function field into
// an ALU function code and flags whether the function field was recognised.
// The function field is only consulted for the register-to-register class.
module ctl_alu_dec
    import ctl_pkg::*;
(
    input  op_class_e         cls,
    input  logic [FN_W-1:0]   funct,
    output logic [ALU_W-1:0]  alu_fn,
    output logic              fn_ok
);
    // Select the ALU function from the class, deferring to funct when needed.
    always_comb begin
        alu_fn = ALU_ADD;
        fn_ok  = 1'b1;
        case (cls)
            CLS_MEM: alu_fn = ALU_ADD;
            CLS_BR:  alu_fn = ALU_SUB;
            CLS_REG: begin
                case (funct)
                    FN_ADD:  alu_fn = ALU_ADD;
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    default: fn_ok  = 1'b0;
                endcase
            end
            default: alu_fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/ctl_decode_top.sv
// Instruction control decoder top: chains the primary and ALU decoders and
// suppresses every side effect of a register-to-register instruction whose
// function field is unsupported. Purely combinational.
module ctl_decode_top
    import ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output logic             wr_sel_rd,
    output logic             opb_sel_imm,
    output logic             wb_sel_mem,
    output logic             rf_we,
    output logic             dmem_re,
    output logic             dmem_we,
    output logic             br_eq,
    output logic [CLS_W-1:0] op_class,
    output logic [ALU_W-1:0] alu_fn
);
    main_ctl_t          main_ctl;
    logic               fn_ok;
    logic [ALU_W-1:0]   fn_code;

    ctl_main_dec i_main (
        .opcode (opcode),
        .ctl    (main_ctl)
    );

    ctl_alu_dec i_alu (
        .cls    (main_ctl.cls),
        .funct  (funct),
        .alu_fn (fn_code),
        .fn_ok  (fn_ok)
    );

    // Drive the outputs, gating side effects when the function is unknown.
    always_comb begin
        wr_sel_rd   = main_ctl.wr_sel_rd;
        opb_sel_imm = main_ctl.opb_sel_imm;
        wb_sel_mem  = main_ctl.wb_sel_mem;
        rf_we       = main_ctl.rf_we & fn_ok;
        dmem_re     = main_ctl.dmem_re & fn_ok;
        dmem_we     = main_ctl.dmem_we & fn_ok;
        br_eq       = main_ctl.br_eq & fn_ok;
        op_class    = main_ctl.cls;
        alu_fn      = fn_code;
    end
endmodule

// File: rtl/ctl_decode_chk.sv
// Checker for the instruction control decoder: immediate assertions on the
// ports, re-evaluated whenever an input or output changes.
module ctl_decode_chk
    import ctl_pkg::*;
(
    input logic [OPC_W-1:0] opcode,
    input logic [FN_W-1:0]  funct,
    input logic             wb_sel_mem,
    input logic             rf_we,
    input logic             dmem_re,
    input logic             dmem_we,
    input logic             br_eq,
    input logic [CLS_W-1:0] op_class,
    input logic [ALU_W-1:0] alu_fn
);
    logic opc_known;
    logic fn_known;

    // Classify the inputs independently of the decoder.
    always_comb begin
        opc_known = (opcode == 6'h00) || (opcode == 6'h23) ||
                    (opcode == 6'h2B) || (opcode == 6'h04);
        fn_known  = (funct == 6'h20) || (funct == 6'h22) ||
                    (funct == 6'h24) || (funct == 6'h25);
    end

    // Check port relations for every input combination.
    always_comb begin
        a_r9_mem_excl: assert (!(dmem_re && dmem_we))
            else $error("R9: both memory enables high");
        if (!opc_known) begin
            a_r7_unknown_safe: assert (!rf_we && !dmem_re && !dmem_we && !br_eq)
                else $error("R7: side effect on unknown opcode");
        end
        if (opcode == 6'h00 && !fn_known) begin
            a_r8_bad_funct_safe: assert (!rf_we && !dmem_re && !dmem_we && !br_eq)
                else $error("R8: side effect on unknown funct");
        end
        if (op_class == 2'b00) begin
            a_r5_mem_add: assert (alu_fn == 4'b0010)
                else $error("R5: memory class not add");
        end
        if (op_class == 2'b01) begin
            a_r5_br_sub: assert (alu_fn == 4'b0110)
                else $error("R5: branch class not subtract");
        end
        if (opcode == 6'h23) begin
            a_r2_load_path: assert (dmem_re && rf_we && wb_sel_mem)
                else $error("R2: load path incomplete");
        end
        if (br_eq) begin
            a_r4_branch_quiet: assert (!rf_we && !dmem_we)
                else $error("R4: branch writes state");
        end
    end
endmodule

bind ctl_decode_top ctl_decode_chk i_chk (
    .opcode     (opcode),
    .funct      (funct),
    .wb_sel_mem (wb_sel_mem),
    .rf_we      (rf_we),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .br_eq      (br_eq),
    .op_class   (op_class),
    .alu_fn     (alu_fn)
);

// File: tb/test_ctl_decode_top.sv
// Directed bench for the instruction control decoder.
module test_ctl_decode_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic [5:0] funct  = 6'h00;
    logic       wr_sel_rd, opb_sel_imm, wb_sel_mem, rf_we;
    logic       dmem_re, dmem_we, br_eq;
    logic [1:0] op_class;
    logic [3:0] alu_fn;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    ctl_decode_top i_ctl_decode_top (
        .opcode      (opcode),
        .funct       (funct),
        .wr_sel_rd   (wr_sel_rd),
        .opb_sel_imm (opb_sel_imm),
        .wb_sel_mem  (wb_sel_mem),
        .rf_we       (rf_we),
        .dmem_re     (dmem_re),
        .dmem_we     (dmem_we),
        .br_eq       (br_eq),
        .op_class    (op_class),
        .alu_fn      (alu_fn)
    );

    // Output vector: [12]wr_sel_rd [11]opb_sel_imm [10]wb_sel_mem [9]rf_we
    // [8]dmem_re [7]dmem_we [6]br_eq [5:4]op_class [3:0]alu_fn
    localparam logic [12:0] M_ALL  = 13'h1FFF;
    localparam logic [12:0] M_SAFE = 13'b0_0011_1100_0000;
    localparam logic [12:0] M_UNK  = 13'b0_0011_1111_0000;
    localparam logic [12:0] M_NOWR = 13'b0_1011_1111_1111;

    function automatic logic [12:0] outs();
        return {wr_sel_rd, opb_sel_imm, wb_sel_mem, rf_we, dmem_re, dmem_we,
                br_eq, op_class, alu_fn};
    endfunction

    task automatic apply(input logic [5:0] op, input logic [5:0] fn);
        @(negedge clk);
        opcode = op;
        funct  = fn;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [12:0] mask,
                       input logic [12:0] exp);
        logic [12:0] act;
        act = outs();
        checks++;
        if ((act & mask) != (exp & mask)) begin
            errors++;
            $display("FAIL %s op=%h fn=%h actual=%b expected=%b mask=%b",
                     req, opcode, funct, act & mask, exp & mask, mask);
        end
    endtask

    // Idle inputs after reset: opcode 0 with funct 0 must be harmless (R8).
    task automatic t_reset_state();
        apply(6'h00, 6'h00);
        chk("R8 reset-state", M_SAFE, 13'h0);
    endtask

    // Register-to-register operations (R1, R6).
    task automatic t_reg_ops();
        logic [5:0] fns [4] = '{6'h20, 6'h22, 6'h24, 6'h25};
        logic [3:0] fcs [4] = '{4'b0010, 4'b0110, 4'b0000, 4'b0001};
        for (int i = 0; i < 4; i++) begin
            apply(6'h00, fns[i]);
            chk("R1", M_ALL & ~13'hF, {7'b1001000, 2'b10, 4'b0000});
            chk("R6", 13'hF, {9'b0, fcs[i]});
        end
    endtask

    // Word load with misleading funct fields (R2, R5).
    task automatic t_load();
        logic [5:0] fns [3] = '{6'h24, 6'h25, 6'h22};
        for (int i = 0; i < 3; i++) begin
            apply(6'h23, fns[i]);
            chk("R2", M_ALL & ~13'hF, {7'b0111100, 2'b00, 4'b0000});
            chk("R5 load-add", 13'hF, {9'b0, 4'b0010});
        end
    endtask

    // Word store (R3, R5).
    task automatic t_store();
        logic [5:0] fns [2] = '{6'h25, 6'h3F};
        for (int i = 0; i < 2; i++) begin
            apply(6'h2B, fns[i]);
            chk("R3", M_NOWR & ~13'hF, {7'b0100010, 2'b00, 4'b0000});
            chk("R5 store-add", 13'hF, {9'b0, 4'b0010});
        end
    endtask

    // Branch-if-equal (R4, R5).
    task automatic t_branch();
        logic [5:0] fns [3] = '{6'h20, 6'h24, 6'h25};
        for (int i = 0; i < 3; i++) begin
            apply(6'h04, fns[i]);
            chk("R4", M_NOWR & ~13'hF, {7'b0000001, 2'b01, 4'b0000});
            chk("R5 branch-sub", 13'hF, {9'b0, 4'b0110});
        end
    endtask

    // Unsupported function codes under the register opcode (R8).
    task automatic t_bad_funct();
        logic [5:0] fns [5] = '{6'h21, 6'h23, 6'h26, 6'h3F, 6'h2A};
        for (int i = 0; i < 5; i++) begin
            apply(6'h00, fns[i]);
            chk("R8", M_SAFE, 13'h0);
        end
    endtask

    // Sweep every opcode: unknown ones safe (R7), enables exclusive (R9).
    task automatic t_opcode_sweep();
        for (int op = 0; op < 64; op++) begin
            apply(6'(op), 6'h20);
            if (op != 'h00 && op != 'h23 && op != 'h2B && op != 'h04)
                chk("R7", M_UNK, {7'b0, 2'b11, 4'b0});
            checks++;
            if (dmem_re && dmem_we) begin
                errors++;
                $display("FAIL R9 op=%h actual re=%b we=%b expected not both",
                         opcode, dmem_re, dmem_we);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_reg_ops();
        t_load();
        t_store();
        t_branch();
        t_bad_funct();
        t_opcode_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule